// File: doc/BRIEF.md
# I2C High-Speed Mode Detector

This block listens to an I2C bus without driving it and tells the rest of the chip which speed regime the bus is in. Out of reset it assumes the standard/fast regime, where the rate is at most 400 kbps. It finds START, repeated START and STOP conditions on already-synchronized SCL and SDA. After each START it shifts in the first byte and then samples the acknowledge bit.

A high-speed master announces the faster regime with a reserved code byte whose upper five bits are `00001`. No device acknowledges that byte. When the detector sees a START, then such a byte, then a NACK, it raises `hs_mode` and reports the three low code bits. It holds `hs_mode` through any number of repeated STARTs and their address and data bytes. Only a STOP clears it. Every change of mode produces a one-cycle pulse, so clock or timing logic can follow the bus rate.

Top module: `i2c_hs_detect`

## Requirements
- R1: After reset `hs_mode` is 0, `mode_chg` is 0 and `mcode_sfx` is 0.
- R2: In standard/fast mode, the sequence START, a byte of the form 0000_1xxx sent MSB first, then a ninth bit of SDA high (NACK) sets `hs_mode` to 1. `mode_chg` is high for exactly one clock, in the same cycle that `hs_mode` changes.
- R3: On entry to high-speed mode, `mcode_sfx` takes the three least significant bits of the code byte. It keeps that value until the next entry.
- R4: A code byte of the form 0000_1xxx followed by an ACK (ninth bit SDA low) leaves `hs_mode` at 0.
- R5: A first byte whose upper five bits are not 00001 never sets `hs_mode`, whatever its ninth bit is.
- R6: While `hs_mode` is 1, repeated STARTs and every following byte leave `hs_mode` and `mcode_sfx` unchanged. This includes bytes that look like a code byte.
- R7: A STOP (SDA rising while SCL is high) during high-speed mode clears `hs_mode` and pulses `mode_chg` once.
- R8: A START or STOP in the middle of a byte abandons the partial byte. After a START, decoding begins again at the first bit.
- R9: Bits clocked on SCL rising edges with no START since the last STOP are ignored.
- R10: A STOP while already in standard/fast mode produces no `mode_chg` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| hs_mode | output | 1 | 1 while the bus is in high-speed mode |
| mode_chg | output | 1 | One-cycle pulse on every mode change |
| mcode_sfx | output | 3 | Low three bits of the last accepted code byte |

## Verification
The assertions assume that SCL and SDA are already synchronized to `clk`. They also assume that each bus level is held for at least two clocks, so an SDA edge and an SCL edge never land in the same sampled cycle. The bench's bus tasks change only one line at a time and hold every level for four clocks. SDA moves only while SCL is low, except when the bench forms a START or STOP on purpose. Under those conditions, a mode change can follow only a sampled SCL-high, SDA-high cycle: the NACK bit on entry, or the STOP on exit.

// File: rtl/i2c_hs_detect.sv
module i2c_hs_detect #(
  parameter int BYTE_W = 8,
  parameter int SFX_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             hs_mode,
  output logic             mode_chg,
  output logic [SFX_W-1:0] mcode_sfx
);
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int HEAD_W = BYTE_W - SFX_W;
  localparam logic [HEAD_W-1:0] HEAD = HEAD_W'(1);

  typedef enum logic [1:0] {WAIT_S, SHIFT, SKIP} phase_t;

  phase_t            phase;
  logic              scl_q, sda_q;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;

  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire scl_rise = scl_i & ~scl_q;
  wire last_bit = (cnt == CNT_W'(BYTE_W));
  wire is_code  = (shreg[BYTE_W-1:SFX_W] == HEAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      phase     <= WAIT_S;
      cnt       <= '0;
      shreg     <= '0;
      hs_mode   <= 1'b0;
      mode_chg  <= 1'b0;
      mcode_sfx <= '0;
    end else begin
      scl_q    <= scl_i;
      sda_q    <= sda_i;
      mode_chg <= 1'b0;
      if (stop_c) begin
        phase <= WAIT_S;
        cnt   <= '0;
        if (hs_mode) begin
          hs_mode  <= 1'b0;
          mode_chg <= 1'b1;
        end
      end else if (start_c) begin
        cnt   <= '0;
        phase <= hs_mode ? SKIP : SHIFT;
      end else if (scl_rise && phase == SHIFT) begin
        if (!last_bit) begin
          shreg <= {shreg[BYTE_W-2:0], sda_i};
          cnt   <= cnt + 1'b1;
        end else begin
          phase <= SKIP;
          if (is_code && sda_i) begin
            hs_mode   <= 1'b1;
            mode_chg  <= 1'b1;
            mcode_sfx <= shreg[SFX_W-1:0];
          end
        end
      end
    end
  end
endmodule

module i2c_hs_detect_chk #(
  parameter int SFX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_i,
  input logic             hs_mode,
  input logic             mode_chg,
  input logic [SFX_W-1:0] mcode_sfx
);
  assert_chg_tracks_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg == (hs_mode != $past(hs_mode)));

  assert_entry_on_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> ($past(sda_i) && $past(scl_i)));

  assert_exit_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_mode) |-> ($past(sda_i) && $past(scl_i)));

  assert_sfx_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(hs_mode) |-> $stable(mcode_sfx));

  assert_hs_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hs_mode) && !$past(sda_i)) |-> hs_mode);
endmodule

bind i2c_hs_detect i2c_hs_detect_chk #(.SFX_W(SFX_W)) u_chk (.*);

// File: tb/i2c_hs_detect_test.sv
module i2c_hs_detect_test;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
  logic hs_mode, mode_chg;
  logic [2:0] mcode_sfx;
  int checks = 0, fails = 0, chg_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_hs_detect uut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
                     .hs_mode(hs_mode), .mode_chg(mode_chg), .mcode_sfx(mcode_sfx));

  always @(negedge clk) if (mode_chg) chg_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (4) @(negedge clk);
  endtask

  task automatic drive(input logic c, input logic d);
    scl = c; sda = d; hold();
  endtask

  task automatic start_c();
    drive(scl, 1'b1); drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b0, 1'b0);
  endtask

  task automatic stop_c();
    drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b1);
  endtask

  task automatic send_bit(input logic b);
    drive(1'b0, b); drive(1'b1, b); drive(1'b0, b);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic t_reset();
    chk("R1 hs_mode", hs_mode, 0);
    chk("R1 mode_chg", mode_chg, 0);
    chk("R1 mcode_sfx", mcode_sfx, 0);
  endtask

  task automatic t_enter_hold_exit();
    int c0 = chg_cnt;
    start_c(); send_byte(8'h0D); send_bit(1'b1);
    chk("R2 hs_mode after code+NACK", hs_mode, 1);
    chk("R2 single pulse on entry", chg_cnt - c0, 1);
    chk("R3 suffix", mcode_sfx, 5);
    send_byte(8'h08); send_bit(1'b1);
    start_c(); send_byte(8'h09); send_bit(1'b1); send_byte(8'h55); send_bit(1'b0);
    chk("R6 hs_mode held", hs_mode, 1);
    chk("R6 suffix held", mcode_sfx, 5);
    chk("R6 no extra pulse", chg_cnt - c0, 1);
    stop_c();
    chk("R7 hs_mode cleared", hs_mode, 0);
    chk("R7 pulse on exit", chg_cnt - c0, 2);
  endtask

  task automatic t_ack();
    start_c(); send_byte(8'h0B); send_bit(1'b0);
    chk("R4 ACKed code stays F/S", hs_mode, 0);
    stop_c();
  endtask

  task automatic t_not_code();
    start_c(); send_byte(8'hA0); send_bit(1'b1);
    chk("R5 address byte", hs_mode, 0);
    stop_c();
    start_c(); send_byte(8'h18); send_bit(1'b1);
    chk("R5 byte 0x18", hs_mode, 0);
    stop_c();
  endtask

  task automatic t_abort();
    start_c(); send_bit(0); send_bit(0); send_bit(0); send_bit(0);
    start_c(); send_byte(8'h0E); send_bit(1'b1);
    chk("R8 realign after START", hs_mode, 1);
    chk("R8 suffix after realign", mcode_sfx, 6);
    stop_c();
    start_c(); send_bit(0); send_bit(0); send_bit(0); send_bit(0); send_bit(1);
    stop_c(); send_bit(1); send_bit(1); send_bit(1); send_bit(1);
    chk("R8 STOP abandons byte", hs_mode, 0);
    stop_c();
  endtask

  task automatic t_no_start();
    send_byte(8'h0A); send_bit(1'b1);
    chk("R9 bits without START", hs_mode, 0);
    chk("R9 suffix untouched", mcode_sfx, 6);
  endtask

  task automatic t_stop_fs();
    int c0 = chg_cnt;
    stop_c();
    chk("R10 no pulse on STOP in F/S", chg_cnt - c0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    hold();
    t_reset();
    t_enter_hold_exit();
    t_ack();
    t_not_code();
    t_abort();
    t_no_start();
    t_stop_fs();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule